// File: doc/BRIEF.md
# External Reset Pulse Generator

This block turns a single-cycle expiry trigger from a watchdog into a timed pulse on an external reset pin. The pulse length is counted in enables from a 1 MHz tick, so a programmed duration value N gives a pulse of N+1 microseconds. Where no write has been made, the length is 256 µs. The pin is driven as a data bit plus an output enable. A pad can therefore be modelled either as push-pull or as open-drain with an external pull-up.

One 32-bit register at a fixed offset holds the configuration. Its low field is the duration. The upper two bits report the output polarity (bit 31, 1 = active-high) and the drive style (bit 30, 1 = push-pull). These two bits are not written as plain bits. Each one changes only when the top byte of a write carries one of four key values. Any other top byte leaves both bits as they were, but the duration field still takes its new value. The duration field is 20 bits wide by default, and a parameter selects a narrower 8-bit variant.

A trigger that arrives while a pulse is running is dropped. The duration is captured when the pulse starts, so a register write during a pulse changes only the next pulse.

Top module: `rstpulse_gen`

## Requirements
- R1: After reset, a read at offset 0x18 returns 0x000000FF (active-low, open-drain, duration 255) and pin_oe is 0.
- R2: A write at offset 0x18 loads bits DUR_W-1:0 of the write data into the duration field. On read, bits 29:DUR_W are always zero, whatever was written there.
- R3: Top byte 0xA5 sets bit 31 (active-high). Top byte 0x5A clears it (active-low).
- R4: Top byte 0xA8 sets bit 30 (push-pull). Top byte 0x8A clears it (open-drain).
- R5: Any other top byte leaves bits 31 and 30 unchanged, and the duration field is still updated by the same write.
- R6: A trigger while idle starts a pulse that lasts for exactly N+1 tick enables, where N is the duration field.
- R7: A trigger that arrives while a pulse is in progress is ignored and starts no further pulse.
- R8: In open-drain mode the data output is 0, and the output enable is 1 only while a pulse is active and the polarity is active-low.
- R9: In push-pull mode the output enable is always 1, and the data output is the polarity level during a pulse and its inverse otherwise.
- R10: The length of a pulse is fixed by the duration value held when the pulse started. A write during the pulse does not change that length.
- R11: Writes to any other offset change nothing, and reads at any other offset return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | ADDR_W | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| tick_1us | input | 1 | 1 MHz count enable |
| trig | input | 1 | Watchdog expiry trigger |
| pin_o | output | 1 | Reset pin data |
| pin_oe | output | 1 | Reset pin output enable |

## Verification
The hardest case to reach is a register write or a second trigger that lands while a pulse is already counting. A write must not shorten or stretch that pulse, and a second trigger must not queue a follow-on pulse. The stimulus fires a trigger and then, a few clocks later and between ticks, issues a new write or a repeated trigger. The scoreboard holds one expected tick count per trigger, and it reports any pulse that arrives with an empty queue as unexpected. Open-drain active-high mode is also tricky, because the pulse cannot be seen at the pin there. In that mode the bench instead confirms that the enable stays low for longer than the whole pulse window.

// File: rtl/rstpulse_pkg.sv
package rstpulse_pkg;

    localparam logic [7:0] KEY_POL_HIGH = 8'hA5;
    localparam logic [7:0] KEY_POL_LOW  = 8'h5A;
    localparam logic [7:0] KEY_DRV_PP   = 8'hA8;
    localparam logic [7:0] KEY_DRV_OD   = 8'h8A;

    localparam int POL_BIT = 31;
    localparam int DRV_BIT = 30;

    typedef struct packed {
        logic pol_high;
        logic push_pull;
    } pin_style_t;

    localparam pin_style_t STYLE_RESET = '{pol_high: 1'b0, push_pull: 1'b0};

    function automatic pin_style_t apply_key(input logic [7:0] key, input pin_style_t cur);
        pin_style_t nxt;
        nxt = cur;
        case (key)
            KEY_POL_HIGH: nxt.pol_high  = 1'b1;
            KEY_POL_LOW:  nxt.pol_high  = 1'b0;
            KEY_DRV_PP:   nxt.push_pull = 1'b1;
            KEY_DRV_OD:   nxt.push_pull = 1'b0;
            default:      nxt = cur;
        endcase
        return nxt;
    endfunction

    function automatic logic is_key(input logic [7:0] key);
        return (key == KEY_POL_HIGH) || (key == KEY_POL_LOW) ||
               (key == KEY_DRV_PP)   || (key == KEY_DRV_OD);
    endfunction

endpackage

// File: rtl/rstpulse_cfg.sv
module rstpulse_cfg
    import rstpulse_pkg::*;
#(
    parameter int          DUR_W   = 20,
    parameter int          ADDR_W  = 8,
    parameter logic [7:0]  OFFSET  = 8'h18,
    parameter logic [7:0]  RST_DUR = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output pin_style_t        style,
    output logic [DUR_W-1:0]  dur
);
    localparam int PAD_W = 30 - DUR_W;

    logic hit;
    assign hit = (addr == ADDR_W'(OFFSET));

    always_ff @(posedge clk) begin
        if (rst) begin
            style <= STYLE_RESET;
            dur   <= DUR_W'(RST_DUR);
        end else if (wr && hit) begin
            style <= apply_key(wdata[31:24], style);
            dur   <= wdata[DUR_W-1:0];
        end
    end

    always_comb begin
        if (hit) rdata = {style.pol_high, style.push_pull, {PAD_W{1'b0}}, dur};
        else     rdata = '0;
    end
endmodule

// File: rtl/rstpulse_timer.sv
module rstpulse_timer #(
    parameter int DUR_W = 20
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             trig,
    input  logic             tick,
    input  logic [DUR_W-1:0] dur,
    output logic             active,
    output logic [DUR_W-1:0] remain
);
    always_ff @(posedge clk) begin
        if (rst) begin
            active <= 1'b0;
            remain <= '0;
        end else if (!active) begin
            if (trig) begin
                active <= 1'b1;
                remain <= dur;
            end
        end else if (tick) begin
            if (remain == '0) active <= 1'b0;
            else              remain <= remain - 1'b1;
        end
    end
endmodule

// File: rtl/rstpulse_pad.sv
module rstpulse_pad
    import rstpulse_pkg::*;
(
    input  logic       active,
    input  pin_style_t style,
    output logic       pin_o,
    output logic       pin_oe
);
    logic level;
    assign level = active ? style.pol_high : ~style.pol_high;

    always_comb begin
        if (style.push_pull) begin
            pin_oe = 1'b1;
            pin_o  = level;
        end else begin
            pin_oe = active & ~style.pol_high;
            pin_o  = 1'b0;
        end
    end
endmodule

// File: rtl/rstpulse_gen.sv
module rstpulse_gen
    import rstpulse_pkg::*;
#(
    parameter int         DUR_W   = 20,
    parameter int         ADDR_W  = 8,
    parameter logic [7:0] OFFSET  = 8'h18,
    parameter logic [7:0] RST_DUR = 8'hFF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic              tick_1us,
    input  logic              trig,
    output logic              pin_o,
    output logic              pin_oe
);
    pin_style_t       style;
    logic [DUR_W-1:0] dur;
    logic             pulse_active;
    logic [DUR_W-1:0] pulse_remain;

    rstpulse_cfg #(
        .DUR_W(DUR_W), .ADDR_W(ADDR_W), .OFFSET(OFFSET), .RST_DUR(RST_DUR)
    ) u_cfg (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
        .rdata(bus_rdata), .style(style), .dur(dur)
    );

    rstpulse_timer #(.DUR_W(DUR_W)) u_timer (
        .clk(clk), .rst(rst), .trig(trig), .tick(tick_1us), .dur(dur),
        .active(pulse_active), .remain(pulse_remain)
    );

    rstpulse_pad u_pad (
        .active(pulse_active), .style(style), .pin_o(pin_o), .pin_oe(pin_oe)
    );
endmodule

// File: rtl/rstpulse_chk.sv
module rstpulse_chk
    import rstpulse_pkg::*;
#(
    parameter int         DUR_W  = 20,
    parameter int         ADDR_W = 8,
    parameter logic [7:0] OFFSET = 8'h18
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              tick_1us,
    input logic              trig,
    input logic              pin_o,
    input logic              pin_oe,
    input logic              pol_high,
    input logic              push_pull,
    input logic              active,
    input logic [DUR_W-1:0]  remain
);
    logic wr_hit;
    assign wr_hit = bus_wr && (bus_addr == ADDR_W'(OFFSET));

    // R3
    a_r3_key_high: assert property (@(posedge clk) disable iff (rst)
        wr_hit && bus_wdata[31:24] == KEY_POL_HIGH |=> pol_high);
    a_r3_key_low: assert property (@(posedge clk) disable iff (rst)
        wr_hit && bus_wdata[31:24] == KEY_POL_LOW |=> !pol_high);
    // R4
    a_r4_key_pp: assert property (@(posedge clk) disable iff (rst)
        wr_hit && bus_wdata[31:24] == KEY_DRV_PP |=> push_pull);
    // R5
    a_r5_other_keeps: assert property (@(posedge clk) disable iff (rst)
        wr_hit && !is_key(bus_wdata[31:24]) |=> $stable(pol_high) && $stable(push_pull));
    // R6
    a_r6_hold_no_tick: assert property (@(posedge clk) disable iff (rst)
        active && !tick_1us |=> active && $stable(remain));
    a_r6_count_down: assert property (@(posedge clk) disable iff (rst)
        active && tick_1us && remain != '0 |=> active && remain == $past(remain) - 1'b1);
    // R7
    a_r7_start_from_idle: assert property (@(posedge clk) disable iff (rst)
        $rose(active) |-> $past(trig));
    // R8
    a_r8_od_low_only: assert property (@(posedge clk) disable iff (rst)
        !push_pull && pin_oe |-> active && !pol_high && !pin_o);
    // R9
    a_r9_pp_driven: assert property (@(posedge clk) disable iff (rst)
        push_pull |-> pin_oe && (pin_o == (active ? pol_high : !pol_high)));
endmodule

bind rstpulse_gen rstpulse_chk #(.DUR_W(DUR_W), .ADDR_W(ADDR_W), .OFFSET(OFFSET)) u_chk (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .tick_1us(tick_1us), .trig(trig), .pin_o(pin_o), .pin_oe(pin_oe),
    .pol_high(style.pol_high), .push_pull(style.push_pull),
    .active(pulse_active), .remain(pulse_remain)
);

// File: tb/sim_rstpulse_gen.sv
module sim_rstpulse_gen;
    localparam int ADDR_W = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_addr = 8'h18;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        tick_1us = 1'b0;
    logic        trig = 1'b0;
    logic        pin_o, pin_oe;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    // bench model of pin style, updated just after the write edge
    bit model_pp = 1'b0;
    bit model_hi = 1'b0;

    int exp_q[$];
    int pulses_done = 0;
    int inv_fail = 0;

    rstpulse_gen u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_1us(tick_1us),
        .trig(trig), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    always #10 clk = ~clk;

    // tick every 5 clocks, driven just after the rising edge
    initial begin
        forever begin
            for (int i = 0; i < 4; i++) @(posedge clk);
            #2 tick_1us = 1'b1;
            @(posedge clk);
            #2 tick_1us = 1'b0;
        end
    end

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // monitor: measures pulses in ticks, pops expected lengths
    bit prev_as = 1'b0;
    int tick_cnt = 0;
    initial begin
        forever begin
            @(negedge clk);
            if (!rst) begin
                bit as;
                as = model_pp ? (pin_oe && (pin_o == model_hi)) : pin_oe;
                if (model_pp && !pin_oe && inv_fail == 0) begin
                    inv_fail++;
                    $display("FAIL R9 push-pull enable actual=%0d expected=1", pin_oe);
                end
                if (!model_pp && pin_oe && (pin_o || model_hi) && inv_fail == 0) begin
                    inv_fail++;
                    $display("FAIL R8 open-drain drive actual=oe%0d/o%0d expected=oe0", pin_oe, pin_o);
                end
                if (as && tick_1us) tick_cnt++;
                if (!as && prev_as) begin
                    if (exp_q.size() == 0) begin
                        check(1'b0, "R7 unexpected pulse", tick_cnt, 0);
                    end else begin
                        int e;
                        e = exp_q.pop_front();
                        check(tick_cnt == e, "R6 pulse length in ticks", tick_cnt, e);
                    end
                    pulses_done++;
                    tick_cnt = 0;
                end
                prev_as = as;
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(posedge clk);
        #1;
        if (a == 8'h18) begin
            case (d[31:24])
                8'hA5: model_hi = 1'b1;
                8'h5A: model_hi = 1'b0;
                8'hA8: model_pp = 1'b1;
                8'h8A: model_pp = 1'b0;
                default: ;
            endcase
        end
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h18;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        @(negedge clk);
        bus_addr = a;
        #1;
        check(bus_rdata == e, req, bus_rdata, e);
        bus_addr = 8'h18;
    endtask

    task automatic fire();
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        trig = 1'b0;
    endtask

    // driver: push expected length, trigger, wait for the monitor
    task automatic pulse(input int n_plus_1, input string req);
        int start;
        start = pulses_done;
        exp_q.push_back(n_plus_1);
        fire();
        for (int i = 0; i < 5000 && pulses_done == start; i++) @(negedge clk);
        check(pulses_done == start + 1, req, pulses_done - start, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(8'h18, 32'h0000_00FF, "R1 reset read");
        check(pin_oe == 1'b0, "R1 reset pin_oe", pin_oe, 0);

        // R2/R5 plain write, no key
        wr(8'h18, 32'h0000_0003);
        rd(8'h18, 32'h0000_0003, "R5 duration update with no key");
        // R11 other offset ignored
        wr(8'h1C, 32'hA500_0009);
        rd(8'h18, 32'h0000_0003, "R11 other offset write ignored");
        rd(8'h1C, 32'h0000_0000, "R11 other offset reads zero");
        // R2 bits 29:20 read zero
        wr(8'h18, 32'hFFF0_0005);
        rd(8'h18, 32'h0000_0005, "R2 upper field bits read zero");

        // R6 open-drain active-low: N=5 -> 6 ticks
        pulse(6, "R6 od active-low pulse");

        // R7 retrigger ignored
        begin
            int base;
            base = pulses_done;
            exp_q.push_back(6);
            fire();
            repeat (8) @(negedge clk);
            fire();
            repeat (120) @(negedge clk);
            check(pulses_done == base + 1, "R7 retrigger gives one pulse", pulses_done - base, 1);
        end

        // R10 write during pulse keeps length
        exp_q.push_back(6);
        fire();
        wr(8'h18, 32'h0000_0001);
        for (int i = 0; i < 200 && exp_q.size() != 0; i++) @(negedge clk);
        repeat (5) @(negedge clk);
        pulse(2, "R10 new duration used by next pulse");

        // R4 push-pull, active-low
        wr(8'h18, 32'hA800_0002);
        rd(8'h18, 32'h4000_0002, "R4 push-pull key");
        check(pin_oe && pin_o, "R9 pp active-low idle high", {pin_oe, pin_o}, 2'b11);
        pulse(3, "R9 pp active-low pulse");

        // R3 active-high
        wr(8'h18, 32'hA500_0002);
        rd(8'h18, 32'hC000_0002, "R3 active-high key");
        check(pin_oe && !pin_o, "R9 pp active-high idle low", {pin_oe, pin_o}, 2'b10);
        pulse(3, "R9 pp active-high pulse");

        // R5 non-key top byte keeps style bits
        wr(8'h18, 32'h1200_0007);
        rd(8'h18, 32'hC000_0007, "R5 other key keeps style");

        // R8 open-drain active-high: enable never asserted
        wr(8'h18, 32'h8A00_0004);
        rd(8'h18, 32'h8000_0004, "R4 open-drain key");
        begin
            int seen;
            seen = 0;
            fire();
            for (int i = 0; i < 60; i++) begin
                @(negedge clk);
                if (pin_oe) seen++;
            end
            check(seen == 0, "R8 od active-high never enables", seen, 0);
        end

        // R3 active-low key, N=0 -> 1 tick
        wr(8'h18, 32'h5A00_0000);
        rd(8'h18, 32'h0000_0000, "R3 active-low key");
        pulse(1, "R6 zero duration one tick");

        // R2 full-width field
        wr(8'h18, 32'h000F_FFFF);
        rd(8'h18, 32'h000F_FFFF, "R2 max duration");

        check(inv_fail == 0, "R8 R9 pin invariants", inv_fail, 0);
        check(exp_q.size() == 0, "R6 scoreboard drained", exp_q.size(), 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule